// File: doc/BRIEF.md
# Sixteen-Level Priority Interrupt Controller

This block decides which of sixteen program priority levels the processor runs. Every level is either active or idle. The running level is the highest-numbered active one, and that number also selects the register bank used by the code on that level. Levels have fixed roles:

- Levels 0 to 9 hold ordinary programs and are switched on and off by software.
- Levels 10 to 13 collect interrupt requests from external devices, with four devices per level.
- Level 14 is raised by internal hardware status errors such as protection faults.
- Level 15 serves very fast user interrupts.

A device request is held as pending until software identifies the device. The ident command names a level. In the next cycle the block answers with the 11-bit identification vector of the lowest-numbered pending device on that level, and that device's request is retired. If no device is pending, the answer carries a no-device flag.

Every input is sampled at a clock edge. The active mask, the running level and the change strobe all reflect that edge's inputs right after it, so a request is seen one cycle after it is presented. The active mask is exported so that a front panel can show it.

Top module: `prio_level_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the active mask is 0, the running level is 0, and the change strobe and ident valid are 0.
- R2: The running level is the highest index set in the active mask, or 0 when the mask is empty. It reflects the inputs of the previous clock edge.
- R3: The change strobe is high for exactly the cycles in which the running level differs from its value in the previous cycle.
- R4: Bit n of the software set input activates level n, and bit n of the software clear input deactivates its software activation. When set and clear hit the same level in one cycle, set wins.
- R5: An internal error request activates level 14. A fast user request activates level 15.
- R6: Device line bit g*4+d marks device d on level 10+g pending. That level stays active while any of its devices is pending, whatever software clears.
- R7: An ident on a level from 10 to 13 gives valid the next cycle. It returns the vector of the lowest-indexed pending device on that level, taken from dev_vec_i bits k*11 +: 11 for device k = g*4+d, and clears that device's pending state.
- R8: An ident on a level with no pending device, or on a level outside 10 to 13, returns vector 0 with the no-device flag set.
- R9: If a device raises its line in the same cycle it is identified, it stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_set_i | input | 16 | Per-level software activation |
| sw_clr_i | input | 16 | Per-level software deactivation |
| err_req_i | input | 1 | Internal status error request (level 14) |
| fast_req_i | input | 1 | Fast user interrupt request (level 15) |
| dev_irq_i | input | 16 | Device request lines, bit g*4+d for level 10+g |
| dev_vec_i | input | 176 | Identification vector of each device, 11 bits apiece |
| ident_req_i | input | 1 | Ident command |
| ident_lvl_i | input | 4 | Level queried by ident |
| run_lvl_o | output | 4 | Currently running level |
| lvl_chg_o | output | 1 | One-cycle pulse on a running-level change |
| active_o | output | 16 | Active-levels mask |
| ident_vld_o | output | 1 | Ident answer valid |
| ident_vec_o | output | 11 | Identification vector of the answering device |
| ident_none_o | output | 1 | Ident found no pending device |

## Verification
A stale or lost pending bit in a device group shows up in two places. It is visible in active_o and run_lvl_o one cycle after the edge concerned. It also appears as a wrong vector or a wrong no-device flag on the next ident of that level. A corrupted activation register or priority choice shows up at once as a running level that is not the top bit of the mask, or as a missing or spurious change strobe. The bench therefore checks the mask, the level and the strobe after every stimulus cycle, and it reads pending devices back only through ident.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int PLC_LEVELS   = 16;
    localparam int PLC_VEC_W    = 11;
    localparam int PLC_EXT_BASE = 10;
    localparam int PLC_EXT_LVLS = 4;
    localparam int PLC_DEVS     = 4;
    localparam int PLC_ERR_LVL  = 14;
    localparam int PLC_FAST_LVL = 15;
endpackage

// File: rtl/plc_prio_enc.sv
module plc_prio_enc #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = W'(i);
        end
    end
endmodule

// File: rtl/plc_ext_group.sv
module plc_ext_group #(
    parameter int DEVS  = 4,
    parameter int VEC_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DEVS-1:0]       irq_i,
    input  logic                  ack_i,
    input  logic [DEVS*VEC_W-1:0] vec_tab_i,
    output logic                  any_o,
    output logic                  any_nxt_o,
    output logic                  hit_o,
    output logic [VEC_W-1:0]      vec_o
);
    logic [DEVS-1:0] pend_d, pend_q;
    logic [DEVS-1:0] first_sel;

    always_comb begin
        first_sel = '0;
        hit_o     = 1'b0;
        vec_o     = '0;
        for (int d = DEVS - 1; d >= 0; d--) begin
            if (pend_q[d]) begin
                first_sel = '0;
                first_sel[d] = 1'b1;
                hit_o     = 1'b1;
                vec_o     = vec_tab_i[d*VEC_W +: VEC_W];
            end
        end
        pend_d = (pend_q & ~(ack_i ? first_sel : '0)) | irq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign any_o     = |pend_q;
    assign any_nxt_o = |pend_d;
endmodule

// File: rtl/prio_level_ctrl.sv
module prio_level_ctrl #(
    parameter int NUM_LVL  = plc_pkg::PLC_LEVELS,
    parameter int VEC_W    = plc_pkg::PLC_VEC_W,
    parameter int EXT_BASE = plc_pkg::PLC_EXT_BASE,
    parameter int EXT_LVLS = plc_pkg::PLC_EXT_LVLS,
    parameter int DEVS     = plc_pkg::PLC_DEVS,
    parameter int ERR_LVL  = plc_pkg::PLC_ERR_LVL,
    parameter int FAST_LVL = plc_pkg::PLC_FAST_LVL,
    localparam int LVL_W   = $clog2(NUM_LVL),
    localparam int NDEV    = EXT_LVLS * DEVS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LVL-1:0]    sw_set_i,
    input  logic [NUM_LVL-1:0]    sw_clr_i,
    input  logic                  err_req_i,
    input  logic                  fast_req_i,
    input  logic [NDEV-1:0]       dev_irq_i,
    input  logic [NDEV*VEC_W-1:0] dev_vec_i,
    input  logic                  ident_req_i,
    input  logic [LVL_W-1:0]      ident_lvl_i,
    output logic [LVL_W-1:0]      run_lvl_o,
    output logic                  lvl_chg_o,
    output logic [NUM_LVL-1:0]    active_o,
    output logic                  ident_vld_o,
    output logic [VEC_W-1:0]      ident_vec_o,
    output logic                  ident_none_o
);
    typedef struct packed {
        logic [NUM_LVL-1:0] act;
        logic [LVL_W-1:0]   run;
        logic               chg;
        logic               vld;
        logic [VEC_W-1:0]   vec;
        logic               none;
    } plc_state_t;

    plc_state_t st_d, st_q;

    logic [EXT_LVLS-1:0]       grp_any, grp_any_nxt, grp_hit, grp_ack;
    logic [VEC_W-1:0]          grp_vec [EXT_LVLS];
    logic [NUM_LVL-1:0]        mask_nxt;
    logic [LVL_W-1:0]          run_nxt;
    logic                      ident_ext;
    int                        ident_grp;

    assign ident_ext = (int'(ident_lvl_i) >= EXT_BASE) &&
                       (int'(ident_lvl_i) <  EXT_BASE + EXT_LVLS);
    assign ident_grp = int'(ident_lvl_i) - EXT_BASE;

    for (genvar g = 0; g < EXT_LVLS; g++) begin : g_grp
        assign grp_ack[g] = ident_req_i && ident_ext && (ident_grp == g);
        plc_ext_group #(.DEVS(DEVS), .VEC_W(VEC_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .irq_i     (dev_irq_i[g*DEVS +: DEVS]),
            .ack_i     (grp_ack[g]),
            .vec_tab_i (dev_vec_i[g*DEVS*VEC_W +: DEVS*VEC_W]),
            .any_o     (grp_any[g]),
            .any_nxt_o (grp_any_nxt[g]),
            .hit_o     (grp_hit[g]),
            .vec_o     (grp_vec[g])
        );
    end

    plc_prio_enc #(.N(NUM_LVL)) u_enc (
        .req_i (mask_nxt),
        .idx_o (run_nxt)
    );

    always_comb begin
        st_d = st_q;
        // software first, then set wins over clear
        st_d.act = (st_q.act & ~sw_clr_i) | sw_set_i;
        if (err_req_i)  st_d.act[ERR_LVL]  = 1'b1;
        if (fast_req_i) st_d.act[FAST_LVL] = 1'b1;
        mask_nxt = st_d.act | (NUM_LVL'(grp_any_nxt) << EXT_BASE);
        st_d.run  = run_nxt;
        st_d.chg  = (run_nxt != st_q.run);
        st_d.vld  = ident_req_i;
        st_d.vec  = '0;
        st_d.none = 1'b1;
        if (ident_req_i) begin
            for (int g = 0; g < EXT_LVLS; g++) begin
                if (grp_ack[g] && grp_hit[g]) begin
                    st_d.vec  = grp_vec[g];
                    st_d.none = 1'b0;
                end
            end
        end else begin
            st_d.none = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o     = st_q.act | (NUM_LVL'(grp_any) << EXT_BASE);
    assign run_lvl_o    = st_q.run;
    assign lvl_chg_o    = st_q.chg;
    assign ident_vld_o  = st_q.vld;
    assign ident_vec_o  = st_q.vec;
    assign ident_none_o = st_q.none;
endmodule

// File: rtl/plc_chk.sv
module plc_chk #(
    parameter int NUM_LVL  = 16,
    parameter int VEC_W    = 11,
    parameter int ERR_LVL  = 14,
    parameter int FAST_LVL = 15,
    localparam int LVL_W   = $clog2(NUM_LVL)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               err_req_i,
    input logic               fast_req_i,
    input logic               ident_req_i,
    input logic [NUM_LVL-1:0] active_o,
    input logic [LVL_W-1:0]   run_lvl_o,
    input logic               lvl_chg_o,
    input logic               ident_vld_o,
    input logic [VEC_W-1:0]   ident_vec_o,
    input logic               ident_none_o
);
    // R2
    top_level_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o != '0) |-> ((active_o >> run_lvl_o) == NUM_LVL'(1)));
    // R2
    idle_runs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o == '0) |-> (run_lvl_o == '0));
    // R3
    change_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_chg_o == (run_lvl_o != $past(run_lvl_o)));
    // R5
    error_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_req_i |=> active_o[ERR_LVL]);
    // R5
    fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_req_i |=> active_o[FAST_LVL]);
    // R7
    ident_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident_req_i |=> ident_vld_o);
    // R7
    no_spurious_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ident_req_i |=> !ident_vld_o);
    // R8
    none_vector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ident_none_o |-> (ident_vec_o == '0));
endmodule

bind prio_level_ctrl plc_chk #(
    .NUM_LVL(NUM_LVL), .VEC_W(VEC_W), .ERR_LVL(ERR_LVL), .FAST_LVL(FAST_LVL)
) u_plc_chk (
    .clk(clk), .rst_n(rst_n), .err_req_i(err_req_i), .fast_req_i(fast_req_i),
    .ident_req_i(ident_req_i), .active_o(active_o), .run_lvl_o(run_lvl_o),
    .lvl_chg_o(lvl_chg_o), .ident_vld_o(ident_vld_o), .ident_vec_o(ident_vec_o),
    .ident_none_o(ident_none_o)
);

// File: tb/tb_prio_level_ctrl.sv
`timescale 1ns/1ps
module tb_prio_level_ctrl;
    logic         clk = 0;
    logic         rst_n = 0;
    logic [15:0]  sw_set = 0, sw_clr = 0, dev_irq = 0;
    logic         err_req = 0, fast_req = 0, ident_req = 0;
    logic [3:0]   ident_lvl = 0;
    logic [175:0] dev_vec;
    logic [3:0]   run_lvl;
    logic         lvl_chg, ident_vld, ident_none;
    logic [15:0]  active;
    logic [10:0]  ident_vec;
    int           checks = 0, errors = 0;
    bit           done = 0;

    always #2.5 clk = ~clk;

    prio_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .sw_set_i(sw_set), .sw_clr_i(sw_clr),
        .err_req_i(err_req), .fast_req_i(fast_req), .dev_irq_i(dev_irq),
        .dev_vec_i(dev_vec), .ident_req_i(ident_req), .ident_lvl_i(ident_lvl),
        .run_lvl_o(run_lvl), .lvl_chg_o(lvl_chg), .active_o(active),
        .ident_vld_o(ident_vld), .ident_vec_o(ident_vec), .ident_none_o(ident_none)
    );

    function automatic logic [10:0] vec_of(int k);
        return 11'((k * 97 + 5) % 2048);
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step(logic [15:0] s, logic [15:0] c, logic e, logic f,
                        logic [15:0] irq, logic idr, logic [3:0] idl);
        sw_set = s; sw_clr = c; err_req = e; fast_req = f;
        dev_irq = irq; ident_req = idr; ident_lvl = idl;
        @(posedge clk); #1;
        sw_set = 0; sw_clr = 0; err_req = 0; fast_req = 0;
        dev_irq = 0; ident_req = 0; ident_lvl = 0;
    endtask

    task automatic check_lvl(string req, logic [15:0] a, logic [3:0] r, logic c);
        check({req, " active"}, 32'(active), 32'(a));
        check({req, " run"}, 32'(run_lvl), 32'(r));
        check({req, " chg"}, 32'(lvl_chg), 32'(c));
    endtask

    typedef struct packed {
        logic [15:0] set;
        logic [15:0] clr;
        logic        err;
        logic        fast;
        logic [15:0] irq;
        logic [15:0] act;
        logic [3:0]  run;
        logic        chg;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t TAB [NROWS] = '{
        '{16'h0008, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0008, 4'd3,  1'b1}, // R4 R2
        '{16'h0080, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0088, 4'd7,  1'b1}, // R2 R3
        '{16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0088, 4'd7,  1'b0}, // R3 hold
        '{16'h0000, 16'h0080, 1'b0, 1'b0, 16'h0000, 16'h0008, 4'd3,  1'b1}, // R4 clear
        '{16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0020, 16'h0808, 4'd11, 1'b1}, // R6
        '{16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000, 16'h4808, 4'd14, 1'b1}, // R5 error
        '{16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0000, 16'hC808, 4'd15, 1'b1}, // R5 fast
        '{16'h0000, 16'hC000, 1'b0, 1'b0, 16'h0000, 16'h0808, 4'd11, 1'b1}, // R4
        '{16'h0008, 16'h0008, 1'b0, 1'b0, 16'h0000, 16'h0808, 4'd11, 1'b0}, // R4 set wins
        '{16'h0000, 16'h0800, 1'b0, 1'b0, 16'h0000, 16'h0808, 4'd11, 1'b0}, // R6 clr no effect
        '{16'h0001, 16'h0000, 1'b0, 1'b0, 16'h0000, 16'h0809, 4'd11, 1'b0}  // R2 lower level
    };

    task automatic ident_check(string req, logic v, logic [10:0] vec, logic none);
        check({req, " vld"}, 32'(ident_vld), 32'(v));
        check({req, " vec"}, 32'(ident_vec), 32'(vec));
        check({req, " none"}, 32'(ident_none), 32'(none));
    endtask

    initial begin
        for (int k = 0; k < 16; k++) dev_vec[k*11 +: 11] = vec_of(k);
        repeat (3) @(posedge clk);
        #1;
        check_lvl("R1 in reset", 16'h0, 4'd0, 1'b0);
        check("R1 vld", 32'(ident_vld), 0);
        rst_n = 1;
        @(posedge clk); #1;
        check_lvl("R1 after reset", 16'h0, 4'd0, 1'b0);

        for (int i = 0; i < NROWS; i++) begin
            step(TAB[i].set, TAB[i].clr, TAB[i].err, TAB[i].fast, TAB[i].irq, 1'b0, 4'd0);
            check_lvl($sformatf("R2 row %0d", i), TAB[i].act, TAB[i].run, TAB[i].chg);
        end

        // R6: two devices on level 10
        step(0, 0, 0, 0, 16'h0005, 0, 0);
        check_lvl("R6 two devs", 16'h0C09, 4'd11, 1'b0);
        // R7 lowest device first
        step(0, 0, 0, 0, 0, 1, 4'd10);
        ident_check("R7 first", 1'b1, vec_of(0), 1'b0);
        check_lvl("R7 level kept", 16'h0C09, 4'd11, 1'b0);
        step(0, 0, 0, 0, 0, 1, 4'd10);
        ident_check("R7 second", 1'b1, vec_of(2), 1'b0);
        check_lvl("R7 level drops", 16'h0809, 4'd11, 1'b0);
        // R8 empty external level
        step(0, 0, 0, 0, 0, 1, 4'd10);
        ident_check("R8 empty", 1'b1, 11'd0, 1'b1);
        step(0, 0, 0, 0, 0, 1, 4'd11);
        ident_check("R7 level 11", 1'b1, vec_of(5), 1'b0);
        check_lvl("R7 R3 run falls", 16'h0009, 4'd3, 1'b1);
        // R8 non-external level
        step(0, 0, 0, 0, 0, 1, 4'd5);
        ident_check("R8 program level", 1'b1, 11'd0, 1'b1);
        // R9 re-request during ident
        step(0, 0, 0, 0, 16'h8000, 0, 0);
        check_lvl("R6 level 13", 16'h2009, 4'd13, 1'b1);
        step(0, 0, 0, 0, 16'h8000, 1, 4'd13);
        ident_check("R9 ident", 1'b1, vec_of(15), 1'b0);
        check_lvl("R9 still pending", 16'h2009, 4'd13, 1'b0);
        step(0, 0, 0, 0, 0, 1, 4'd13);
        ident_check("R9 second ident", 1'b1, vec_of(15), 1'b0);
        check_lvl("R9 cleared", 16'h0009, 4'd3, 1'b1);
        step(0, 0, 0, 0, 0, 0, 0);
        ident_check("R7 idle", 1'b0, 11'd0, 1'b0);
        // R1 reset mid-run
        step(0, 0, 1, 0, 16'h0010, 0, 0);
        rst_n = 0; #1;
        check_lvl("R1 mid reset", 16'h0, 4'd0, 1'b0);
        @(posedge clk); #1;
        rst_n = 1;
        @(posedge clk); #1;
        check_lvl("R1 post reset", 16'h0, 4'd0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule